// File: doc/BRIEF.md
# Eight-Operation Byte ALU with Registered Inputs

This block is the arithmetic and logic unit of a small 8-bit accumulator-style processor core. The sequencer presents two operand bytes, a 3-bit operation code and the current flags byte, and raises a load strobe. The unit captures all of these in input registers on that clock edge. For the whole cycle that follows, the unit computes the result byte and the updated flags byte from the captured values, and the sequencer moves them into its own registers at the next edge.

The unit performs addition and subtraction, each with and without the incoming carry, the three bitwise operations, and a compare. The compare subtracts only to produce flags and returns the first operand unchanged. The unit builds the complete flags byte, and the bits that carry no defined meaning pass from the incoming flags to the outgoing flags untouched. Software that saves the flags and later restores them therefore sees those bits preserved.

Top module: `byte_alu`

## Requirements
- R1: The operation code selects 0=ADD, 1=ADC (add with carry), 2=SUB, 3=SBB (subtract with borrow), 4=AND, 5=XOR, 6=OR, 7=CMP (compare).
- R2: For ADD and ADC the result is the low 8 bits of A+B. ADC also adds the incoming carry. CY is the carry out of bit 7 and AC is the carry out of bit 3.
- R3: For SUB and SBB the result is the low 8 bits of A-B. SBB also subtracts the incoming carry. CY is set when a borrow occurs. AC is the carry out of bit 3 of the internal sum A + ~B + (1 for SUB, or the inverse of the incoming carry for SBB).
- R4: CMP produces exactly the flags SUB would produce on the same operands, and its result byte equals operand A.
- R5: S equals bit 7 of the computed value, Z is set when that value is zero, and P is set when that value has an even number of one bits. The computed value is the difference for CMP and the result byte for every other operation.
- R6: The outgoing flags byte places S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bits 5, 3 and 1 are copied from the captured incoming flags byte.
- R7: AND clears CY and sets AC to the OR of bit 3 of the two operands.
- R8: XOR and OR clear both CY and AC.
- R9: Operands, operation and flags are captured on a rising edge where `load` is high, and the outputs reflect them from that edge on. While `load` is low the outputs hold. `res_fresh` is high for exactly the cycle after a load edge.
- R10: A synchronous active-high reset clears all captured values and `res_fresh`. After reset the outputs are result 0x00 and flags 0x44.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture the operands, operation and flags at this edge |
| opnd_a | input | 8 | First operand (accumulator) |
| opnd_b | input | 8 | Second operand |
| op_sel | input | 3 | Operation code |
| flags_in | input | 8 | Incoming flags byte |
| result | output | 8 | Result byte from the captured inputs |
| flags_out | output | 8 | Updated flags byte |
| res_fresh | output | 1 | High during the cycle after a load |

## Verification
The hardest conditions to reach from the ports are the borrow-dependent cases of SBB. These are an incoming carry that turns an equal-operand subtract into a borrow, and a nibble borrow that changes AC with no full borrow. Each is reached with hand-picked operand pairs and both settings of the incoming carry. For CMP, the operand pairs place the difference and operand A on opposite sides of every flag, so that computing the flags from the wrong byte shows up. For the undefined bits, the incoming flags are chosen with only bits 5, 3 and 1 set and again with all other bits set. A sweep over many operand pairs for every code then compares the outputs against a model written from the requirements.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;

    localparam int FLG_S  = 7;
    localparam int FLG_Z  = 6;
    localparam int FLG_U5 = 5;
    localparam int FLG_AC = 4;
    localparam int FLG_U3 = 3;
    localparam int FLG_P  = 2;
    localparam int FLG_U1 = 1;
    localparam int FLG_CY = 0;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_XOR = 3'd5,
        OP_OR  = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        alu_op_e           op;
        logic [7:0]        fl;
    } alu_req_t;

    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic              cy;
        logic              ac;
    } alu_part_t;

    function automatic logic even_ones(input logic [DATA_W-1:0] v);
        return ~(^v);
    endfunction

    function automatic logic is_sub(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    endfunction

    function automatic logic is_arith(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || is_sub(op);
    endfunction

endpackage

// File: rtl/alu_in_reg.sv
module alu_in_reg
    import alu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  alu_req_t req_d,
    output alu_req_t req_q,
    output logic     fresh_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            fresh_q <= 1'b0;
        end else begin
            fresh_q <= load;
            if (load) begin
                req_q <= req_d;
            end
        end
    end

    assert_capture_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> (req_q == $past(req_d)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(req_q));

endmodule

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           op,
    input  logic              cy_in,
    output alu_part_t         part
);

    logic              sub;
    logic [DATA_W-1:0] b_eff;
    logic              cin;
    logic [DATA_W:0]   full_sum;
    logic [NIB_W:0]    low_sum;

    always_comb begin
        sub   = is_sub(op);
        b_eff = sub ? ~b : b;
        unique case (op)
            OP_ADD:  cin = 1'b0;
            OP_ADC:  cin = cy_in;
            OP_SBB:  cin = ~cy_in;
            default: cin = 1'b1;
        endcase
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
        low_sum  = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, cin};
        part.val = full_sum[DATA_W-1:0];
        part.cy  = sub ? ~full_sum[DATA_W] : full_sum[DATA_W];
        part.ac  = low_sum[NIB_W];
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           op,
    output alu_part_t         part
);

    always_comb begin
        part.cy = 1'b0;
        unique case (op)
            OP_AND: begin
                part.val = a & b;
                part.ac  = a[NIB_W-1] | b[NIB_W-1];
            end
            OP_XOR: begin
                part.val = a ^ b;
                part.ac  = 1'b0;
            end
            default: begin
                part.val = a | b;
                part.ac  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [2:0]        op_sel,
    input  logic [7:0]        flags_in,
    output logic [DATA_W-1:0] result,
    output logic [7:0]        flags_out,
    output logic              res_fresh
);

    alu_req_t  req_d;
    alu_req_t  req_q;
    alu_part_t arith_p;
    alu_part_t logic_p;
    alu_part_t sel_p;

    always_comb begin
        req_d.a  = opnd_a;
        req_d.b  = opnd_b;
        req_d.op = alu_op_e'(op_sel);
        req_d.fl = flags_in;
    end

    alu_in_reg u_in (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .req_d   (req_d),
        .req_q   (req_q),
        .fresh_q (res_fresh)
    );

    alu_arith u_arith (
        .a     (req_q.a),
        .b     (req_q.b),
        .op    (req_q.op),
        .cy_in (req_q.fl[FLG_CY]),
        .part  (arith_p)
    );

    alu_logic u_logic (
        .a    (req_q.a),
        .b    (req_q.b),
        .op   (req_q.op),
        .part (logic_p)
    );

    always_comb begin
        sel_p  = is_arith(req_q.op) ? arith_p : logic_p;
        result = (req_q.op == OP_CMP) ? req_q.a : sel_p.val;
        flags_out[FLG_S]  = sel_p.val[DATA_W-1];
        flags_out[FLG_Z]  = (sel_p.val == '0);
        flags_out[FLG_U5] = req_q.fl[FLG_U5];
        flags_out[FLG_AC] = sel_p.ac;
        flags_out[FLG_U3] = req_q.fl[FLG_U3];
        flags_out[FLG_P]  = even_ones(sel_p.val);
        flags_out[FLG_U1] = req_q.fl[FLG_U1];
        flags_out[FLG_CY] = sel_p.cy;
    end

    assert_cmp_keeps_a_R4: assert property (@(posedge clk) disable iff (rst)
        (req_q.op == OP_CMP) |-> (result == req_q.a));

    assert_undef_pass_R6: assert property (@(posedge clk) disable iff (rst)
        (flags_out[FLG_U5] == req_q.fl[FLG_U5]) &&
        (flags_out[FLG_U3] == req_q.fl[FLG_U3]) &&
        (flags_out[FLG_U1] == req_q.fl[FLG_U1]));

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (req_q.op != OP_CMP) |-> (flags_out[FLG_Z] == (result == '0)));

    assert_logic_no_carry_R8: assert property (@(posedge clk) disable iff (rst)
        !is_arith(req_q.op) |-> !flags_out[FLG_CY]);

    assert_fresh_after_load_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> res_fresh);

endmodule

// File: tb/test_byte_alu.sv
module test_byte_alu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_b = 8'h00;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] flags_in = 8'h00;
    logic [7:0] result;
    logic [7:0] flags_out;
    logic       res_fresh;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    byte_alu i_byte_alu (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .op_sel    (op_sel),
        .flags_in  (flags_in),
        .result    (result),
        .flags_out (flags_out),
        .res_fresh (res_fresh)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [7:0] a, input logic [7:0] b,
                                          input logic [2:0] op, input logic [7:0] fi);
        int s; int lo; int c; int cyv; int acv;
        logic [7:0] v; logic [7:0] r; logic [7:0] f;
        c = fi[0];
        cyv = 0; acv = 0;
        case (op)
            3'd0, 3'd1: begin
                if (op == 3'd0) c = 0;
                s = a + b + c;
                lo = (a & 15) + (b & 15) + c;
                cyv = (s > 255); acv = (lo > 15); v = s[7:0];
            end
            3'd2, 3'd3, 3'd7: begin
                if (op != 3'd3) c = 0;
                s = int'(a) - int'(b) - c;
                lo = (a & 15) + ((~b) & 15) + (1 - c);
                cyv = (s < 0); acv = (lo > 15); v = s[7:0];
            end
            3'd4: begin v = a & b; acv = a[3] | b[3]; end
            3'd5: v = a ^ b;
            default: v = a | b;
        endcase
        r = (op == 3'd7) ? a : v;
        f = 8'h00;
        f[7] = v[7];
        f[6] = (v == 0);
        f[5] = fi[5];
        f[4] = acv[0];
        f[3] = fi[3];
        f[2] = ~(^v);
        f[1] = fi[1];
        f[0] = cyv[0];
        return {r, f};
    endfunction

    task automatic run_op(input string req, input logic [7:0] a, input logic [7:0] b,
                          input logic [2:0] op, input logic [7:0] fi);
        logic [15:0] e;
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sel = op; flags_in = fi; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        e = model(a, b, op, fi);
        chk({req, " result"}, result, e[15:8]);
        chk({req, " flags"}, flags_out, e[7:0]);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R10 result", result, 8'h00);
        chk("R10 flags", flags_out, 8'h44);
        chk("R10 fresh", {7'd0, res_fresh}, 8'h00);
    endtask

    task automatic t_add;
        run_op("R2 add carry-out", 8'h3A, 8'hC6, 3'd0, 8'h00);
        chk("R2 add flags literal", flags_out, 8'h55);
        run_op("R2 add sign", 8'h40, 8'h41, 3'd0, 8'h01);
        run_op("R2 adc carry in", 8'h0F, 8'h00, 3'd1, 8'h01);
        chk("R2 adc literal", result, 8'h10);
        run_op("R2 adc wrap", 8'hFF, 8'h00, 3'd1, 8'h01);
    endtask

    task automatic t_sub;
        run_op("R3 sub borrow", 8'h10, 8'h20, 3'd2, 8'h00);
        chk("R3 sub cy literal", {7'd0, flags_out[0]}, 8'h01);
        run_op("R3 sub nibble", 8'h10, 8'h01, 3'd2, 8'h00);
        run_op("R3 sbb equal with carry", 8'h55, 8'h55, 3'd3, 8'h01);
        chk("R3 sbb literal", result, 8'hFF);
        run_op("R3 sbb equal no carry", 8'h55, 8'h55, 3'd3, 8'h00);
        run_op("R3 sbb nibble borrow", 8'h20, 8'h0F, 3'd3, 8'h01);
    endtask

    task automatic t_cmp;
        run_op("R4 cmp equal", 8'h7E, 8'h7E, 3'd7, 8'h00);
        chk("R4 cmp keeps A", result, 8'h7E);
        chk("R5 cmp Z from difference", {7'd0, flags_out[6]}, 8'h01);
        run_op("R4 cmp less", 8'h01, 8'h02, 3'd7, 8'h00);
        run_op("R4 cmp greater", 8'h80, 8'h01, 3'd7, 8'h01);
    endtask

    task automatic t_logic;
        run_op("R7 and ac", 8'h08, 8'hF0, 3'd4, 8'h01);
        chk("R7 and flag literal", flags_out & 8'h11, 8'h10);
        run_op("R7 and no ac", 8'hF7, 8'hF7, 3'd4, 8'h01);
        run_op("R8 xor", 8'h0F, 8'h0F, 3'd5, 8'h11);
        chk("R8 xor flag literal", flags_out & 8'h11, 8'h00);
        run_op("R8 or", 8'h88, 8'h07, 3'd6, 8'h11);
    endtask

    task automatic t_undef;
        run_op("R6 undef set", 8'h01, 8'h01, 3'd0, 8'h2A);
        chk("R6 undef bits kept", flags_out & 8'h2A, 8'h2A);
        run_op("R6 undef clear", 8'h01, 8'h01, 3'd0, 8'hD5);
        chk("R6 undef bits clear", flags_out & 8'h2A, 8'h00);
        run_op("R1 R6 code 5", 8'hA5, 8'h5A, 3'd5, 8'hFF);
    endtask

    task automatic t_hold;
        logic [7:0] r0; logic [7:0] f0;
        run_op("R9 load", 8'h12, 8'h34, 3'd0, 8'h00);
        chk("R9 fresh after load", {7'd0, res_fresh}, 8'h01);
        r0 = result; f0 = flags_out;
        opnd_a = 8'hFF; opnd_b = 8'hFF; op_sel = 3'd3; flags_in = 8'hFF;
        @(negedge clk);
        chk("R9 hold result", result, r0);
        chk("R9 hold flags", flags_out, f0);
        chk("R9 fresh drops", {7'd0, res_fresh}, 8'h00);
    endtask

    task automatic t_sweep;
        for (int op = 0; op < 8; op++) begin
            for (int k = 0; k < 24; k++) begin
                run_op("R1 sweep", 8'((k * 37 + op * 11) & 255), 8'((k * 91 + 5) & 255),
                       3'(op), 8'((k & 1) | ((k * 3) & 8'h2A)));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        t_add;
        t_sub;
        t_cmp;
        t_logic;
        t_undef;
        t_hold;
        t_sweep;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule